// File: doc/BRIEF.md
# I2C Bus Unstick Sequencer

This block frees a two-wire bus that a peripheral has left stuck, typically because a reset arrived in the middle of a byte and the peripheral is still holding the data line low. A single-cycle start request starts a fixed recovery sequence, and the block runs it with no further input.

The sequence first waits a bounded time for the attached bus controller to finish any transfer it has in flight. It then holds that controller in soft reset and takes direct control of both lines through open-drain enables. It clocks SCL until both lines read high, gives up after a bounded number of pulses, and forces a start condition followed by a stop condition. Only after that does it release the controller and report completion, with a failure flag if the lines never came free.

All delays are counts of system clock cycles set by parameters. The default parameters suit a 200 MHz clock, with a 100 µs half-period for the pulses and a 1 ms interval for the start and stop holds. A bench can make these counts small.

Top module: `i2c_unstick`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, scl_oe_o, sda_oe_o and ctrl_srst_o are all 0. An enable at 1 pulls its line low, and an enable at 0 releases the line.
- R2: start_i is accepted only while the block is idle. busy_o is 1 from the cycle after acceptance up to the completion cycle, where it is 0. A start_i pulse while busy is ignored: it produces no second completion and does not change the sequence timing.
- R3: xfer_pend_i is sampled in the first cycle after acceptance, and then once every POLL_GAP_CYC+1 cycles, for at most POLL_LIMIT samples. ctrl_srst_o rises in the cycle after the first sample that reads 0. If no sample reads 0, it rises in the cycle after the last sample.
- R4: ctrl_srst_o stays 1 whenever either enable is 1. It falls exactly LONG_CYC cycles after sda_oe_o falls. done_o rises exactly LONG_CYC cycles after ctrl_srst_o falls.
- R5: Once ctrl_srst_o rises, both lines are released for HALF_CYC cycles, and then the line levels are checked in a one-cycle check step. Each pulse drives scl_oe_o to 1 for HALF_CYC cycles and to 0 for HALF_CYC cycles, and a check step follows each pulse. The line inputs pass through a two-flop synchroniser before they are checked.
- R6: Pulsing stops at the first check step that sees both lines high. At most PULSE_LIMIT pulses are issued.
- R7: After the last check step, sda_oe_o is 1 for exactly LONG_CYC cycles while scl_oe_o stays 0 (start condition). sda_oe_o then returns to 0 while scl_oe_o stays 0 (stop condition).
- R8: done_o is a one-cycle pulse. fail_o is 1 in that same cycle exactly when the check step after the last allowed pulse still saw a line low. The start and stop conditions are issued in the failing case as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to run the sequence |
| xfer_pend_i | input | 1 | Controller reports a transfer in flight |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | With done_o: lines never both read high |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| ctrl_srst_o | output | 1 | Holds the bus controller in soft reset |

## Verification
The bench models a peripheral that holds SDA low for a chosen number of SCL pulses. Counts of zero, ten and eleven separate the no-pulse path, the last pulse that still passes, and the failing path. An SCL line held low permanently checks that the pulse limit is honoured no matter which line is stuck. The pending input is cleared at varied times, including just before and just after a poll instant and never at all, which shows whether the soft-reset edge follows the sampling grid. Random mixes of these settings are compared against a cycle-exact timing model of the whole sequence.

// File: rtl/ubs_pkg.sv
package ubs_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_POLL,
      ST_POLL_GAP,
      ST_RELEASE,
      ST_CHECK,
      ST_PULSE_LO,
      ST_PULSE_HI,
      ST_START,
      ST_STOP,
      ST_UNRESET,
      ST_DONE
   } ubs_state_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/ubs_sync.sv
module ubs_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ubs_sync needs at least two stages");
      end
   endgenerate

   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], async_i[b]};
         end
         assign sync_o[b] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ubs_timer.sv
module ubs_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] val_i,
   output logic          zero_o
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load_i)      cnt <= val_i;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign zero_o = (cnt == '0);

   assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !zero_o) |=> (cnt == $past(cnt) - 1'b1));
   assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt == $past(val_i)));
endmodule

// File: rtl/ubs_fsm.sv
module ubs_fsm
   import ubs_pkg::*;
#(
   parameter int POLL_LIMIT   = 10,
   parameter int POLL_GAP_CYC = 100000,
   parameter int HALF_CYC     = 20000,
   parameter int LONG_CYC     = 200000,
   parameter int PULSE_LIMIT  = 10,
   parameter int TW           = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          pend_i,
   input  logic          scl_s_i,
   input  logic          sda_s_i,
   input  logic          tmr_zero_i,
   output logic          tmr_load_o,
   output logic [TW-1:0] tmr_val_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          fail_o,
   output logic          scl_oe_o,
   output logic          sda_oe_o,
   output logic          srst_o
);
   localparam int PCW = $clog2(POLL_LIMIT + 1);
   localparam int QCW = $clog2(PULSE_LIMIT + 1);

   ubs_state_e     state, nxt;
   logic [PCW-1:0] poll_cnt;
   logic [QCW-1:0] pulse_cnt;
   logic           fail_q;
   logic           lines_free;
   logic           last_poll;
   logic           pulse_cap;

   assign lines_free = scl_s_i & sda_s_i;
   assign last_poll  = (poll_cnt == PCW'(POLL_LIMIT - 1));
   assign pulse_cap  = (pulse_cnt == QCW'(PULSE_LIMIT));

   function automatic logic [TW-1:0] dur_of(input ubs_state_e s);
      case (s)
         ST_POLL_GAP:                         return TW'(POLL_GAP_CYC - 1);
         ST_RELEASE, ST_PULSE_LO, ST_PULSE_HI: return TW'(HALF_CYC - 1);
         ST_START, ST_STOP, ST_UNRESET:        return TW'(LONG_CYC - 1);
         default:                              return '0;
      endcase
   endfunction

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:     if (start_i) nxt = ST_POLL;
         ST_POLL:     nxt = (!pend_i || last_poll) ? ST_RELEASE : ST_POLL_GAP;
         ST_POLL_GAP: if (tmr_zero_i) nxt = ST_POLL;
         ST_RELEASE:  if (tmr_zero_i) nxt = ST_CHECK;
         ST_CHECK: begin
            if (lines_free || pulse_cap) nxt = ST_START;
            else                         nxt = ST_PULSE_LO;
         end
         ST_PULSE_LO: if (tmr_zero_i) nxt = ST_PULSE_HI;
         ST_PULSE_HI: if (tmr_zero_i) nxt = ST_CHECK;
         ST_START:    if (tmr_zero_i) nxt = ST_STOP;
         ST_STOP:     if (tmr_zero_i) nxt = ST_UNRESET;
         ST_UNRESET:  if (tmr_zero_i) nxt = ST_DONE;
         ST_DONE:     nxt = ST_IDLE;
         default:     nxt = ST_IDLE;
      endcase
   end

   assign tmr_load_o = (nxt != state);
   assign tmr_val_o  = dur_of(nxt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         poll_cnt  <= '0;
         pulse_cnt <= '0;
         fail_q    <= 1'b0;
      end else begin
         state <= nxt;
         if (state == ST_IDLE && start_i) begin
            poll_cnt  <= '0;
            pulse_cnt <= '0;
            fail_q    <= 1'b0;
         end
         if (state == ST_POLL) poll_cnt <= poll_cnt + 1'b1;
         if (state == ST_CHECK && nxt == ST_PULSE_LO) pulse_cnt <= pulse_cnt + 1'b1;
         if (state == ST_CHECK && !lines_free && pulse_cap) fail_q <= 1'b1;
      end
   end

   assign busy_o   = (state != ST_IDLE) && (state != ST_DONE);
   assign done_o   = (state == ST_DONE);
   assign fail_o   = (state == ST_DONE) && fail_q;
   assign scl_oe_o = (state == ST_PULSE_LO);
   assign sda_oe_o = (state == ST_START);
   assign srst_o   = (state == ST_RELEASE) || (state == ST_CHECK) ||
                     (state == ST_PULSE_LO) || (state == ST_PULSE_HI) ||
                     (state == ST_START) || (state == ST_STOP);

   assert_poll_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      poll_cnt <= PCW'(POLL_LIMIT));
   assert_srst_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(srst_o) |-> ($past(state) == ST_POLL));
   assert_lines_guarded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_oe_o || sda_oe_o) |-> srst_o);
   assert_pulse_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_cnt <= QCW'(PULSE_LIMIT));
   assert_start_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe_o |-> !scl_oe_o);
   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_fail_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |-> done_o);
   assert_busy_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   assert_ignore_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (busy_o || done_o));
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick
   import ubs_pkg::*;
#(
   parameter int POLL_LIMIT   = 10,
   parameter int POLL_GAP_CYC = 100000,
   parameter int HALF_CYC     = 20000,
   parameter int LONG_CYC     = 200000,
   parameter int PULSE_LIMIT  = 10,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic xfer_pend_i,
   input  logic scl_i,
   input  logic sda_i,
   output logic busy_o,
   output logic done_o,
   output logic fail_o,
   output logic scl_oe_o,
   output logic sda_oe_o,
   output logic ctrl_srst_o
);
   localparam int DMAX = max3(POLL_GAP_CYC, HALF_CYC, LONG_CYC);
   localparam int TW   = (DMAX < 2) ? 1 : $clog2(DMAX);

   generate
      if (POLL_LIMIT < 1)   begin : g_bad_poll  $error("POLL_LIMIT must be at least 1"); end
      if (PULSE_LIMIT < 1)  begin : g_bad_pulse $error("PULSE_LIMIT must be at least 1"); end
      if (POLL_GAP_CYC < 1) begin : g_bad_gap   $error("POLL_GAP_CYC must be at least 1"); end
      if (LONG_CYC < 1)     begin : g_bad_long  $error("LONG_CYC must be at least 1"); end
      if (HALF_CYC < SYNC_STAGES + 1) begin : g_bad_half
         $error("HALF_CYC must cover the synchroniser latency");
      end
   endgenerate

   logic [1:0]    lines_s;
   logic          tmr_load, tmr_zero;
   logic [TW-1:0] tmr_val;

   ubs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({scl_i, sda_i}),
      .sync_o  (lines_s)
   );

   ubs_timer #(.TW(TW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .zero_o (tmr_zero)
   );

   ubs_fsm #(
      .POLL_LIMIT   (POLL_LIMIT),
      .POLL_GAP_CYC (POLL_GAP_CYC),
      .HALF_CYC     (HALF_CYC),
      .LONG_CYC     (LONG_CYC),
      .PULSE_LIMIT  (PULSE_LIMIT),
      .TW           (TW)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .pend_i     (xfer_pend_i),
      .scl_s_i    (lines_s[1]),
      .sda_s_i    (lines_s[0]),
      .tmr_zero_i (tmr_zero),
      .tmr_load_o (tmr_load),
      .tmr_val_o  (tmr_val),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .fail_o     (fail_o),
      .scl_oe_o   (scl_oe_o),
      .sda_oe_o   (sda_oe_o),
      .srst_o     (ctrl_srst_o)
   );

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!scl_oe_o && !sda_oe_o && !ctrl_srst_o));
endmodule

// File: tb/tb_i2c_unstick.sv
`timescale 1ns/1ps
module tb_i2c_unstick;
   localparam int PL   = 10;
   localparam int GAP  = 3;
   localparam int HALF = 4;
   localparam int LONG = 6;
   localparam int QL   = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic pend = 1'b0;
   logic busy, done, fail, scl_oe, sda_oe, srst;
   logic scl_line, sda_line;

   int cyc = 0;
   int n_chk = 0, n_bad = 0;
   bit hung = 0;

   // bench-side line model
   bit pend_arm = 0;
   int t0 = 1000000000;
   int drop = 0;
   int sda_hold = 0;
   int pulse_base = 0;
   bit scl_stuck = 0;

   // monitor records
   int pulses_tot = 0, done_tot = 0, viol_tot = 0, done_w = 0;
   int t_srst_rise = 0, t_srst_fall = 0, t_sda_rise = 0, t_sda_fall = 0, t_done = 0;
   bit fail_seen = 0;
   logic p_srst = 0, p_sda = 0, p_scl = 0;

   always #2.5 clk = ~clk;

   assign scl_line = !scl_oe && !scl_stuck;
   assign sda_line = !sda_oe && !((pulses_tot - pulse_base) < sda_hold);

   i2c_unstick #(
      .POLL_LIMIT(PL), .POLL_GAP_CYC(GAP), .HALF_CYC(HALF),
      .LONG_CYC(LONG), .PULSE_LIMIT(QL), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .xfer_pend_i(pend),
      .scl_i(scl_line), .sda_i(sda_line),
      .busy_o(busy), .done_o(done), .fail_o(fail),
      .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .ctrl_srst_o(srst)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      pend = pend_arm && !(cyc >= t0 + drop);
      if (rst_n) begin
         if (srst && !p_srst) t_srst_rise = cyc;
         if (!srst && p_srst) t_srst_fall = cyc;
         if (sda_oe && !p_sda) t_sda_rise = cyc;
         if (!sda_oe && p_sda) t_sda_fall = cyc;
         if (scl_oe && !p_scl) pulses_tot++;
         if (done) begin
            done_w++;
            done_tot++;
            t_done = cyc;
            fail_seen = fail;
         end
         if ((sda_oe && scl_oe) || ((sda_oe || scl_oe) && !srst) || (busy && done)) viol_tot++;
         p_srst = srst; p_sda = sda_oe; p_scl = scl_oe;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_polls(input int m);
      for (int k = 1; k <= PL; k++)
         if (1 + (k - 1) * (GAP + 1) > m) return k;
      return PL;
   endfunction

   function automatic int exp_pulses(input int hold, input bit stuck);
      if (stuck) return QL;
      return (hold < QL) ? hold : QL;
   endfunction

   task automatic run_case(input int m, input int hold, input bit stuck, input bit extra);
      int polls, p, dpoll, total, d0, v0, wd;
      bit efail;
      polls = exp_polls(m);
      p     = exp_pulses(hold, stuck);
      efail = stuck || (hold > QL);
      dpoll = 1 + (polls - 1) * (GAP + 1);
      total = dpoll + HALF + (p + 1) + 2 * p * HALF + 3 * LONG;

      @(negedge clk);
      drop = m; sda_hold = hold; scl_stuck = stuck;
      pulse_base = pulses_tot; pend_arm = 1;
      d0 = done_tot; v0 = viol_tot; done_w = 0;
      start = 1'b1;
      @(posedge clk); #1;
      t0 = cyc; start = 1'b0;
      if (extra) begin
         repeat (5) @(negedge clk);
         check("R2 busy before second start", int'(busy), 1);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wd = 0;
      while (done_tot == d0 && wd < 5000) begin
         @(negedge clk);
         wd++;
      end
      if (wd >= 5000) begin
         hung = 1;
         check("watchdog", 1, 0);
         return;
      end
      repeat (8) @(negedge clk);
      check("R3 soft reset rise delay", t_srst_rise - t0, dpoll);
      check("R6 pulse count", pulses_tot - pulse_base, p);
      check("R7 start hold length", t_sda_fall - t_sda_rise, LONG);
      check("R4 soft reset release after stop", t_srst_fall - t_sda_fall, LONG);
      check("R4 done after release", t_done - t_srst_fall, LONG);
      check("R5 total sequence length", t_done - t0, total);
      check("R8 fail flag", int'(fail_seen), int'(efail));
      check("R8 done width", done_w, 1);
      check("R2 single completion", done_tot - d0, 1);
      check("R2 idle after done", int'(busy), 0);
      check("R4 R7 line guard violations", viol_tot - v0, 0);
      pend_arm = 0; scl_stuck = 0; sda_hold = 0; t0 = 1000000000;
   endtask

   initial begin
      void'($urandom(32'd7351));
      repeat (4) @(negedge clk);
      check("R1 busy at reset", int'(busy), 0);
      check("R1 srst at reset", int'(srst), 0);
      check("R1 enables at reset", int'(scl_oe | sda_oe), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 done/fail after reset", int'(done | fail), 0);
      check("R1 srst after reset", int'(srst), 0);

      // directed corners
      if (!hung) run_case(0, 0, 0, 0);    // R3 immediate, R6 no pulses
      if (!hung) run_case(0, 1, 0, 0);
      if (!hung) run_case(4, 3, 0, 0);    // R3 just before second poll
      if (!hung) run_case(5, 3, 0, 0);    // R3 just after second poll
      if (!hung) run_case(200, 2, 0, 0);  // R3 pend never clears
      if (!hung) run_case(0, 10, 0, 0);   // R6 last allowed pulse frees bus
      if (!hung) run_case(0, 11, 0, 0);   // R8 fail
      if (!hung) run_case(8, 0, 1, 0);    // R6 SCL stuck low
      if (!hung) run_case(2, 4, 0, 1);    // R2 start while busy ignored

      for (int i = 0; i < 25 && !hung; i++) begin
         run_case(int'($urandom_range(0, 45)), int'($urandom_range(0, 12)),
                  ($urandom_range(0, 7) == 0), ($urandom_range(0, 3) == 0));
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule